// File: doc/BRIEF.md
# MDIO Management Frame Master

This block drives single register transactions on a two-wire PHY management bus: a clock line it always owns, and a data line it drives and releases through a separate output enable. A command carries a direction (read or write), a 5-bit PHY address, a 5-bit register address and, for writes, 16 bits of data. The master serialises the whole frame, manages the turnaround, and for reads assembles the 16 returned bits. It pulses a one-cycle completion strobe at the end.

The bus clock runs from a divider. Each half-period lasts `div_i + 1` system clocks, and the value is taken when the command is accepted. Every frame opens with an unusually long run of forty ones. It closes with one extra bus clock during which the data line is released, so the PHY sees an idle clock before the master goes quiet. Only one transaction is in flight at a time. A command offered while one is running is dropped.

Top module: `mdio_master`

## Requirements
- R1: After reset, `busy_o`, `done_o`, `mdc_o` and `mdio_oe_o` are all 0.
- R2: A command with `cmd_valid_i` high while `busy_o` is low is accepted, and `busy_o` is 1 from the next cycle. A command offered while `busy_o` is high is ignored: it starts no frame and adds no `done_o` pulse.
- R3: Slots 0 to 39 of every frame carry a 1 on `mdio_o`, with `mdio_oe_o` high from slot 0.
- R4: Slots 40 to 53 carry 0,1, then the opcode (1,0 for a read, 0,1 for a write), then the PHY address and then the register address, each MSB first.
- R5: Each slot is a low phase of `mdc_o` followed by a high phase, each exactly DIV+1 system clocks long. `mdio_o` and `mdio_oe_o` change only at slot boundaries, so they are stable across every rising edge of `mdc_o`.
- R6: A write (`cmd_write_i`=1) drives 1,0 in slots 54 and 55, then write data MSB first in slots 56 to 71, and releases the line in slot 72. The frame has 73 clock pulses.
- R7: A read (`cmd_write_i`=0) releases the line from slot 54, which is turnaround. It samples `mdio_i` at the end of the high phase of slots 55 to 70, MSB first, and ends after slot 71. The frame has 72 clock pulses. `rdata_o` then holds the captured word.
- R8: `done_o` is high for exactly one cycle, and `busy_o` falls in that same cycle. `done_o` appears pulses*2*(DIV+1) cycles after the first cycle in which `busy_o` is high.
- R9: Whenever `busy_o` is low, `mdc_o` and `mdio_oe_o` are low.
- R10: The divider value is captured at acceptance. Changes to `div_i` during a transaction do not alter its timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command offer |
| cmd_write_i | input | 1 | 1 = write, 0 = read |
| phy_addr_i | input | 5 | Target PHY address |
| reg_addr_i | input | 5 | Target register address |
| wdata_i | input | 16 | Write data |
| div_i | input | DIV_W | Half-period minus one, in system clocks |
| busy_o | output | 1 | Transaction in progress |
| done_o | output | 1 | One-cycle completion strobe |
| rdata_o | output | 16 | Last word read |
| mdc_o | output | 1 | Management clock |
| mdio_o | output | 1 | Data line drive value |
| mdio_oe_o | output | 1 | Data line drive enable |
| mdio_i | input | 1 | Data line sampled value |

## Verification
`busy_o` rises one cycle after the accepting edge. `done_o` follows 146*(DIV+1) cycles later for a write and 144*(DIV+1) for a read. Bus bits are due at each `mdc_o` rise, and read bits are due by the end of that slot's high phase. A PHY model watches for `mdc_o` rises on the falling system-clock edge and records the driven bit and the enable. During the read window it presents the next data bit at that point, so the bit is settled before the master samples it at least one system clock later. The monitor measures every half-period in falling-edge counts. It also checks the latency from the `busy_o` rise to `done_o` against the formula, using the divider recorded by the driver and not the live input.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int ADDR_W     = 5;
  localparam int DATA_W     = 16;
  localparam int PRE_BITS   = 40;
  localparam int HDR_BITS   = 4 + 2 * ADDR_W;
  localparam int TA_BITS    = 2;
  localparam int TX_W       = PRE_BITS + HDR_BITS + TA_BITS + DATA_W;
  localparam int RD_TA_SLOT = PRE_BITS + HDR_BITS;
  localparam int RD_FIRST   = RD_TA_SLOT + 1;
  localparam int RD_LAST    = RD_FIRST + DATA_W - 1;
  localparam int RD_END     = RD_LAST + 1;
  localparam int WR_END     = TX_W;
  localparam int SLOT_W     = $clog2(WR_END + 1);

  typedef enum logic [1:0] {
    OP_WR = 2'b01,
    OP_RD = 2'b10
  } mdio_op_e;
endpackage

// File: rtl/mdio_phase_gen.sv
module mdio_phase_gen #(
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             mdc_o,
  output logic             slot_end_o
);
  logic [DIV_W-1:0] cnt_q;
  logic             phase_q;
  logic             wrap;

  assign wrap = (cnt_q == div_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      phase_q <= 1'b0;
    end else if (!run_i) begin
      cnt_q   <= '0;
      phase_q <= 1'b0;
    end else if (wrap) begin
      cnt_q   <= '0;
      phase_q <= ~phase_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign mdc_o      = phase_q;
  // last cycle of the high phase closes a slot
  assign slot_end_o = run_i & phase_q & wrap;
endmodule

// File: rtl/mdio_frame_seq.sv
module mdio_frame_seq
  import mdio_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] phy_i,
  input  logic [ADDR_W-1:0] reg_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              slot_end_i,
  output logic              active_o,
  output logic              done_o,
  output logic              mdio_o,
  output logic              oe_o,
  output logic              sample_o
);
  localparam logic [SLOT_W-1:0] L_WR_END  = SLOT_W'(WR_END);
  localparam logic [SLOT_W-1:0] L_RD_END  = SLOT_W'(RD_END);
  localparam logic [SLOT_W-1:0] L_RD_TA   = SLOT_W'(RD_TA_SLOT);
  localparam logic [SLOT_W-1:0] L_RD_FRST = SLOT_W'(RD_FIRST);
  localparam logic [SLOT_W-1:0] L_RD_LAST = SLOT_W'(RD_LAST);

  logic              active_q, wr_q, done_q;
  logic [SLOT_W-1:0] slot_q;
  logic [TX_W-1:0]   tx_q;
  logic [SLOT_W-1:0] last_slot, drive_end;
  logic [TX_W-1:0]   frame;
  mdio_op_e          op;

  assign op        = wr_i ? OP_WR : OP_RD;
  assign frame     = {{PRE_BITS{1'b1}}, 2'b01, op, phy_i, reg_i,
                      (wr_i ? {2'b10, wdata_i} : {(TA_BITS + DATA_W){1'b0}})};
  assign last_slot = wr_q ? L_WR_END : L_RD_END;
  assign drive_end = wr_q ? L_WR_END : L_RD_TA;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      wr_q     <= 1'b0;
      done_q   <= 1'b0;
      slot_q   <= '0;
      tx_q     <= '0;
    end else begin
      done_q <= 1'b0;
      if (load_i && !active_q) begin
        active_q <= 1'b1;
        wr_q     <= wr_i;
        slot_q   <= '0;
        tx_q     <= frame;
      end else if (active_q && slot_end_i) begin
        if (slot_q == last_slot) begin
          active_q <= 1'b0;
          done_q   <= 1'b1;
        end else begin
          slot_q <= slot_q + 1'b1;
          tx_q   <= {tx_q[TX_W-2:0], 1'b0};
        end
      end
    end
  end

  assign active_o = active_q;
  assign done_o   = done_q;
  assign oe_o     = active_q & (slot_q < drive_end);
  assign mdio_o   = oe_o & tx_q[TX_W-1];
  assign sample_o = active_q & ~wr_q & slot_end_i &
                    (slot_q >= L_RD_FRST) & (slot_q <= L_RD_LAST);
endmodule

// File: rtl/mdio_rx_shift.sv
module mdio_rx_shift #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         sample_i,
  input  logic         bit_i,
  output logic [W-1:0] data_o
);
  logic [W-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       sh_q <= '0;
    else if (sample_i) sh_q <= {sh_q[W-2:0], bit_i};
  end

  assign data_o = sh_q;
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  input  logic              cmd_write_i,
  input  logic [ADDR_W-1:0] phy_addr_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DIV_W-1:0]  div_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              mdc_o,
  output logic              mdio_o,
  output logic              mdio_oe_o,
  input  logic              mdio_i
);
  logic             active, accept, slot_end, sample;
  logic [DIV_W-1:0] div_q;

  assign accept = cmd_valid_i & ~active;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     div_q <= '0;
    else if (accept) div_q <= div_i;
  end

  mdio_phase_gen #(.DIV_W(DIV_W)) u_phase (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .run_i      (active),
    .div_i      (div_q),
    .mdc_o      (mdc_o),
    .slot_end_o (slot_end)
  );

  mdio_frame_seq u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (accept),
    .wr_i       (cmd_write_i),
    .phy_i      (phy_addr_i),
    .reg_i      (reg_addr_i),
    .wdata_i    (wdata_i),
    .slot_end_i (slot_end),
    .active_o   (active),
    .done_o     (done_o),
    .mdio_o     (mdio_o),
    .oe_o       (mdio_oe_o),
    .sample_o   (sample)
  );

  mdio_rx_shift #(.W(DATA_W)) u_rx (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sample_i (sample),
    .bit_i    (mdio_i),
    .data_o   (rdata_o)
  );

  assign busy_o = active;
endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic cmd_valid_i,
  input logic busy_o,
  input logic done_o,
  input logic mdc_o,
  input logic mdio_o,
  input logic mdio_oe_o
);
  p_idle_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!mdc_o && !mdio_oe_o));

  p_accept_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && !busy_o) |=> busy_o);

  p_done_single_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_done_ends_busy_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  p_stable_rise_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mdc_o) |-> ($stable(mdio_o) && $stable(mdio_oe_o)));

  p_hold_high_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mdc_o && $past(mdc_o)) |-> $stable(mdio_o));
endmodule

bind mdio_master mdio_master_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cmd_valid_i (cmd_valid_i),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .mdc_o       (mdc_o),
  .mdio_o      (mdio_o),
  .mdio_oe_o   (mdio_oe_o)
);

// File: tb/sim_mdio_master.sv
`timescale 1ns/1ps
module sim_mdio_master;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0, cmd_write = 1'b0;
  logic [4:0]  phy_addr = '0, reg_addr = '0;
  logic [15:0] wdata = '0;
  logic [7:0]  div = '0;
  logic        busy, done, mdc, mdio_out, mdio_oe;
  logic        mdio_in = 1'b1;
  logic [15:0] rdata;

  always #2.5 clk = ~clk;

  mdio_master #(.DIV_W(8)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cmd_valid), .cmd_write_i(cmd_write),
    .phy_addr_i(phy_addr), .reg_addr_i(reg_addr), .wdata_i(wdata), .div_i(div),
    .busy_o(busy), .done_o(done), .rdata_o(rdata), .mdc_o(mdc),
    .mdio_o(mdio_out), .mdio_oe_o(mdio_oe), .mdio_i(mdio_in)
  );

  typedef struct {
    bit        wr;
    bit [4:0]  phy;
    bit [4:0]  rg;
    bit [15:0] wd;
    bit [7:0]  dv;
  } item_t;

  item_t     exp_q[$];
  int        n_chk = 0, n_fail = 0, n_done = 0;
  bit        finished = 1'b0;
  bit [15:0] phy_data = '0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor state
  bit        rx_bits[0:79];
  bit        oe_bits[0:79];
  bit        p_busy = 0, p_mdc = 0, p_mdio = 0, p_done = 0;
  int        nrise = 0, run = 0, half_err = 0, stab_err = 0;
  longint    cyc = 0, t_start = 0;
  int        cur_div = 0;

  function automatic bit exp_bit(input item_t e, input int i);
    bit [17:0] tail;
    if (i < 40) return 1'b1;
    if (i == 40) return 1'b0;
    if (i == 41) return 1'b1;
    if (i == 42) return ~e.wr;
    if (i == 43) return e.wr;
    if (i < 49) return e.phy[48 - i];
    if (i < 54) return e.rg[53 - i];
    tail = {2'b10, e.wd};
    return tail[71 - i];
  endfunction

  task automatic compare();
    item_t e;
    int    pulses, bad_hdr, bad_oe, bad_pre, bad_dat;
    n_done++;
    if (exp_q.size() == 0) begin
      chk(1'b0, "R2 unexpected done", 1, 0);
      return;
    end
    e = exp_q.pop_front();
    pulses = e.wr ? 73 : 72;
    bad_pre = 0; bad_hdr = 0; bad_oe = 0; bad_dat = 0;
    chk(nrise == pulses, e.wr ? "R6 pulse count" : "R7 pulse count", nrise, pulses);
    for (int i = 0; i < 40; i++) if (!rx_bits[i] || !oe_bits[i]) bad_pre++;
    chk(bad_pre == 0, "R3 preamble bits/enable", bad_pre, 0);
    for (int i = 40; i < 54; i++) if (rx_bits[i] != exp_bit(e, i)) bad_hdr++;
    chk(bad_hdr == 0, "R4 start/op/addr bits", bad_hdr, 0);
    for (int i = 40; i < pulses && i < 80; i++)
      if (oe_bits[i] != (e.wr ? (i < 72) : (i < 54))) bad_oe++;
    chk(bad_oe == 0, e.wr ? "R6 drive enable pattern" : "R7 release pattern", bad_oe, 0);
    if (e.wr) begin
      for (int i = 54; i < 72; i++) if (rx_bits[i] != exp_bit(e, i)) bad_dat++;
      chk(bad_dat == 0, "R6 turnaround/data bits", bad_dat, 0);
    end else begin
      chk(rdata == phy_data, "R7 read data", rdata, phy_data);
    end
    chk(half_err == 0, "R5/R10 half-period length", half_err, 0);
    chk(stab_err == 0, "R5 data stable across MDC high", stab_err, 0);
    chk(cyc - t_start == longint'(pulses) * 2 * (e.dv + 1), "R8 latency",
        cyc - t_start, longint'(pulses) * 2 * (e.dv + 1));
    chk(!busy && !mdc && !mdio_oe, "R9 idle at done", {busy, mdc, mdio_oe}, 0);
  endtask

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (busy && !p_busy) begin
        nrise = 0; run = 1; half_err = 0; stab_err = 0; t_start = cyc;
        cur_div = (exp_q.size() > 0) ? int'(exp_q[0].dv) : 0;
      end else if (busy || done) begin
        if (mdc == p_mdc) run++;
        else begin
          if (run != cur_div + 1) half_err++;
          run = 1;
        end
        if (mdc && !p_mdc) begin
          if (mdio_out != p_mdio) stab_err++;
          if (nrise < 80) begin
            rx_bits[nrise] = mdio_out;
            oe_bits[nrise] = mdio_oe;
          end
          mdio_in = (nrise >= 55 && nrise <= 70) ? phy_data[70 - nrise] : 1'b1;
          nrise++;
        end else if (mdc && p_mdc && mdio_out != p_mdio) stab_err++;
      end
      if (p_done) chk(!done, "R8 done width", done, 0);
      if (done) compare();
    end
    p_busy = busy; p_mdc = mdc; p_mdio = mdio_out; p_done = done;
  end

  task automatic issue(input bit wr, input bit [4:0] pa, input bit [4:0] ra,
                       input bit [15:0] wd, input bit [15:0] pd, input bit [7:0] dv);
    item_t e;
    while (busy || done) @(negedge clk);
    @(negedge clk);
    phy_data = pd;
    e.wr = wr; e.phy = pa; e.rg = ra; e.wd = wd; e.dv = dv;
    exp_q.push_back(e);
    cmd_write = wr; phy_addr = pa; reg_addr = ra; wdata = wd; div = dv;
    cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(busy, "R2 busy after accept", busy, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !done && !mdc && !mdio_oe, "R1 reset outputs",
        {busy, done, mdc, mdio_oe}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !mdc && !mdio_oe, "R9 idle after reset", {busy, mdc, mdio_oe}, 0);

    issue(1'b1, 5'h13, 5'h0A, 16'hA5C3, 16'h0000, 8'd1);
    issue(1'b0, 5'h01, 5'h1F, 16'h0000, 16'h8E71, 8'd0);
    // R2: command while busy must be dropped
    repeat (20) @(negedge clk);
    cmd_write = 1'b1; phy_addr = 5'h1E; reg_addr = 5'h11; wdata = 16'h1234; div = 8'd5;
    cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    issue(1'b0, 5'h00, 5'h00, 16'h0000, 16'h0001, 8'd3);
    // R10: divider input changes mid-frame
    repeat (30) @(negedge clk);
    div = 8'd0;
    issue(1'b1, 5'h1F, 5'h15, 16'h8001, 16'h0000, 8'd2);
    while (busy || done) @(negedge clk);
    repeat (50) @(negedge clk);
    chk(n_done == 4, "R2 done count (ignored command)", n_done, 4);
    chk(exp_q.size() == 0, "R2 scoreboard drained", exp_q.size(), 0);
    chk(!busy && !mdc && !mdio_oe, "R9 idle at end", {busy, mdc, mdio_oe}, 0);
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=complete");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end
endmodule